// File: doc/BRIEF.md
# Microstep Phase Indexer

This block turns a step pulse train into per-phase current commands for a two-phase bipolar stepper motor. It holds a 7-bit electrical-angle index that covers one full electrical cycle in 128 positions, or 2.8125 degrees per position. On each rising edge of the step input, the index moves forward or backward by a stride that depends on the selected resolution.

For each winding the index is turned into a sign bit and a 5-bit magnitude code. Winding A follows the cosine of the angle and winding B the sine, so B lags A by a quarter period. A downstream current DAC and bridge stage consume these codes.

A home strobe returns the index to the 45-degree position. The same strobe is the only moment at which a new resolution is accepted. A monitor flag is low whenever the index sits at home. One of the resolution codes is a standby setting: it steps like full step but drops the drive-enable output.

Top module: `microstep_indexer`

## Requirements
- R1: The index moves only in the clock cycle after a low-to-high transition of `step_in` is sampled. A high-to-low transition, or a level held high, leaves every output unchanged.
- R2: The resolution code `mode` selects the stride per step. 000 is standby (stride 32), 001 is full step (32), 010 is half step with full-current diagonals (16), 011 is quarter step (8), 100 is half step with 71% diagonals (16), 101 is eighth step (4), 110 is sixteenth step (2), and 111 is thirty-second step (1).
- R3: With `dir_cw` = 1 the stride is added to the index; with `dir_cw` = 0 it is subtracted. The index wraps modulo 128.
- R4: While `angle_rst` is high, the index is held at home (index 16, 45 degrees), steps are ignored, and `angle_mon` is low.
- R5: `angle_mon` is low exactly when the index equals home, and high at every other index.
- R6: For index i, `b_mag` = round(31·|sin(i·π/64)|) and `a_mag` = round(31·|cos(i·π/64)|). `b_neg`/`a_neg` are 1 exactly when the sine/cosine is negative, and never set with a zero magnitude.
- R7: In modes 000, 001 and 010, any index with i mod 32 = 16 (an odd multiple of 45 degrees) drives both magnitudes to 31. In the other modes the index drives the value from R6 (22 at home).
- R8: In standby (000), `drive_en` is low while stepping still follows the full-step stride. In every other mode `drive_en` is high.
- R9: `mode` is captured only on clock edges where `angle_rst` is high. A change at any other time has no effect on stride, magnitudes or `drive_en`.
- R10: While `rst_n` is low, the index is home, the captured mode is standby and `drive_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Step pulse; rising edge advances the angle |
| dir_cw | input | 1 | Direction: 1 adds, 0 subtracts |
| mode | input | 3 | Resolution code, captured while `angle_rst` is high |
| angle_rst | input | 1 | Home strobe and mode capture |
| a_neg | output | 1 | Winding A polarity, 1 = negative |
| a_mag | output | 5 | Winding A current magnitude code |
| b_neg | output | 1 | Winding B polarity, 1 = negative |
| b_mag | output | 5 | Winding B current magnitude code |
| drive_en | output | 1 | Bridge enable, low in standby |
| angle_mon | output | 1 | Low at the home angle |

## Verification
The bench walks one whole electrical cycle in every resolution and in both directions, and checks both windings at each position against sine and cosine computed in real arithmetic.

- A wrong stride or a swapped direction would drift off the expected index within a step or two.
- Missing the 100% diagonal override in the full-step and type-(a) half-step modes would show 22 instead of 31 at home.
- Sign bits are checked at the zero crossings, where a sloppy comparison would flag a zero magnitude as negative.
- Steps are issued while the home strobe is high, with a held-high step level, and with a mode change that has no strobe. A design that counted levels, stepped during home, or let the mode slip in early would show it as a moved angle or a changed stride.

// File: rtl/microstep_indexer.sv
module microstep_indexer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_in,
  input  logic       dir_cw,
  input  logic [2:0] mode,
  input  logic       angle_rst,
  output logic       a_neg,
  output logic [4:0] a_mag,
  output logic       b_neg,
  output logic [4:0] b_mag,
  output logic       drive_en,
  output logic       angle_mon
);
  localparam int unsigned IDX_W = 7;
  localparam int unsigned MAG_W = 5;
  localparam logic [IDX_W-1:0] HOME = IDX_W'(16);
  localparam logic [IDX_W-1:0] HALF_CYCLE = IDX_W'(64);
  localparam logic [IDX_W-1:0] QUARTER = IDX_W'(32);

  logic [IDX_W-1:0] idx;
  logic [2:0]       mode_q;
  logic             step_q;
  logic [2:0]       shift;
  logic [IDX_W-1:0] stride;
  logic             rise;
  logic             diag_full;
  logic [IDX_W-1:0] idx_a;

  function automatic logic [MAG_W-1:0] qsin(input logic [5:0] k);
    case (k)
      6'd0:  qsin = 5'd0;
      6'd1:  qsin = 5'd2;
      6'd2:  qsin = 5'd3;
      6'd3:  qsin = 5'd5;
      6'd4:  qsin = 5'd6;
      6'd5:  qsin = 5'd8;
      6'd6:  qsin = 5'd9;
      6'd7:  qsin = 5'd10;
      6'd8:  qsin = 5'd12;
      6'd9:  qsin = 5'd13;
      6'd10: qsin = 5'd15;
      6'd11: qsin = 5'd16;
      6'd12: qsin = 5'd17;
      6'd13: qsin = 5'd18;
      6'd14: qsin = 5'd20;
      6'd15: qsin = 5'd21;
      6'd16: qsin = 5'd22;
      6'd17: qsin = 5'd23;
      6'd18: qsin = 5'd24;
      6'd19: qsin = 5'd25;
      6'd20: qsin = 5'd26;
      6'd21: qsin = 5'd27;
      6'd22: qsin = 5'd27;
      6'd23: qsin = 5'd28;
      6'd24: qsin = 5'd29;
      6'd25: qsin = 5'd29;
      6'd26: qsin = 5'd30;
      6'd27: qsin = 5'd30;
      6'd28: qsin = 5'd30;
      default: qsin = 5'd31;
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] fold_mag(input logic [IDX_W-1:0] i);
    logic [5:0] r;
    r = {1'b0, i[4:0]};
    fold_mag = i[5] ? qsin(6'd32 - r) : qsin(r);
  endfunction

  always_comb begin
    case (mode_q)
      3'b010, 3'b100: shift = 3'd1;
      3'b011:         shift = 3'd2;
      3'b101:         shift = 3'd3;
      3'b110:         shift = 3'd4;
      3'b111:         shift = 3'd5;
      default:        shift = 3'd0;
    endcase
  end

  assign stride    = QUARTER >> shift;
  assign rise      = step_in & ~step_q;
  assign diag_full = (mode_q == 3'b000) || (mode_q == 3'b001) || (mode_q == 3'b010);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= HOME;
      mode_q <= 3'b000;
      step_q <= 1'b0;
    end else begin
      step_q <= step_in;
      if (angle_rst) begin
        idx    <= HOME;
        mode_q <= mode;
      end else if (rise) begin
        idx <= dir_cw ? idx + stride : idx - stride;
      end
    end
  end

  assign idx_a = idx + QUARTER;

  always_comb begin
    if (diag_full && idx[4:0] == 5'd16) begin
      a_mag = 5'd31;
      b_mag = 5'd31;
    end else begin
      a_mag = fold_mag(idx_a);
      b_mag = fold_mag(idx);
    end
  end

  assign b_neg     = idx > HALF_CYCLE;
  assign a_neg     = idx_a > HALF_CYCLE;
  assign drive_en  = (mode_q != 3'b000);
  assign angle_mon = ~angle_rst & (idx != HOME);
endmodule

module microstep_indexer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step_in,
  input logic       angle_rst,
  input logic [2:0] mode,
  input logic [6:0] idx,
  input logic       a_neg,
  input logic [4:0] a_mag,
  input logic       b_neg,
  input logic [4:0] b_mag,
  input logic       drive_en,
  input logic       angle_mon
);
  assert_home_mon_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    angle_rst |-> !angle_mon);
  assert_home_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    angle_rst |=> (idx == 7'd16));
  assert_no_move_without_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(step_in) && !angle_rst) |=> $stable(idx));
  assert_sign_nonzero_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    a_neg |-> (a_mag != 5'd0));
  assert_sign_nonzero_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b_neg |-> (b_mag != 5'd0));
  assert_one_strong_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mag >= 5'd22) || (b_mag >= 5'd22));
  assert_standby_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (angle_rst && mode == 3'b000) |=> !drive_en);
  assert_mode_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !angle_rst |=> $stable(drive_en));
endmodule

bind microstep_indexer microstep_indexer_chk u_chk (.*);

// File: tb/test_microstep_indexer.sv
module test_microstep_indexer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_in = 1'b0;
  logic       dir_cw = 1'b1;
  logic [2:0] mode = 3'b000;
  logic       angle_rst = 1'b0;
  logic       a_neg, b_neg, drive_en, angle_mon;
  logic [4:0] a_mag, b_mag;

  int total = 0;
  int bad = 0;
  int model_idx = 16;
  int cur_mode = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  microstep_indexer i_microstep_indexer (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_cw(dir_cw), .mode(mode),
    .angle_rst(angle_rst), .a_neg(a_neg), .a_mag(a_mag), .b_neg(b_neg),
    .b_mag(b_mag), .drive_en(drive_en), .angle_mon(angle_mon)
  );

  function automatic int stride_of(input int m);
    case (m)
      2, 4: return 16;
      3: return 8;
      5: return 4;
      6: return 2;
      7: return 1;
      default: return 32;
    endcase
  endfunction

  function automatic int rmag(input real v);
    real x;
    x = (v < 0.0) ? -v : v;
    return $rtoi(31.0 * x + 0.5);
  endfunction

  task automatic check_out(input string req, input int i, input int m, input bit rst_level);
    real ang, sv, cv;
    int ea, eb;
    bit ena, enb, emon, een;
    ang = 3.14159265358979 * i / 64.0;
    sv = $sin(ang);
    cv = $cos(ang);
    ea = rmag(cv);
    eb = rmag(sv);
    if (m <= 2 && (i % 32) == 16) begin ea = 31; eb = 31; end
    ena = cv < -1.0e-9;
    enb = sv < -1.0e-9;
    emon = !rst_level && (i != 16);
    een = (m != 0);
    total++;
    if (a_mag != 5'(ea) || b_mag != 5'(eb) || a_neg != ena || b_neg != enb ||
        angle_mon != emon || drive_en != een) begin
      bad++;
      $display("FAIL %s idx=%0d mode=%0d actual a=%b/%0d b=%b/%0d mon=%b en=%b expected a=%b/%0d b=%b/%0d mon=%b en=%b",
               req, i, m, a_neg, a_mag, b_neg, b_mag, angle_mon, drive_en,
               ena, ea, enb, eb, emon, een);
    end
  endtask

  task automatic home_with(input int m);
    @(negedge clk);
    mode = 3'(m);
    angle_rst = 1'b1;
    @(negedge clk);
    check_out("R4", 16, m, 1'b1);
    angle_rst = 1'b0;
    cur_mode = m;
    model_idx = 16;
    @(negedge clk);
    check_out("R7", 16, m, 1'b0);
  endtask

  task automatic do_step(input bit cw, input string req);
    @(negedge clk);
    dir_cw = cw;
    step_in = 1'b1;
    @(negedge clk);
    model_idx = cw ? (model_idx + stride_of(cur_mode)) % 128
                   : (model_idx - stride_of(cur_mode) + 128) % 128;
    check_out(req, model_idx, cur_mode, 1'b0);
    step_in = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out("R10", 16, 0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R10", 16, 0, 1'b0);

    // R2 R3 R5 R6 R7 R8: full cycle each mode, both directions
    for (int m = 0; m < 8; m++) begin
      home_with(m);
      for (int s = 0; s < 128 / stride_of(m); s++) do_step(1'b1, "R3_cw");
      for (int s = 0; s < 128 / stride_of(m); s++) do_step(1'b0, "R3_ccw");
    end

    // R1: held high and falling edge do nothing
    home_with(7);
    do_step(1'b1, "R1");
    @(negedge clk); step_in = 1'b1;
    @(negedge clk);
    model_idx = model_idx + 1;
    check_out("R1", model_idx, 7, 1'b0);
    repeat (3) @(negedge clk);
    check_out("R1", model_idx, 7, 1'b0);
    step_in = 1'b0;
    repeat (2) @(negedge clk);
    check_out("R1", model_idx, 7, 1'b0);

    // R4: steps during home strobe ignored
    @(negedge clk); angle_rst = 1'b1; mode = 3'b111;
    @(negedge clk); step_in = 1'b1;
    @(negedge clk); step_in = 1'b0;
    @(negedge clk);
    check_out("R4", 16, 7, 1'b1);
    angle_rst = 1'b0;
    model_idx = 16;
    @(negedge clk);
    check_out("R5", 16, 7, 1'b0);

    // R9: mode change without strobe ignored (still 1/32 stride, enabled)
    @(negedge clk); mode = 3'b000;
    repeat (2) @(negedge clk);
    do_step(1'b1, "R9");
    do_step(1'b0, "R9");
    do_step(1'b0, "R9");

    // R8: standby after strobe, then mode 1 stride and enable
    home_with(0);
    do_step(1'b0, "R8");
    home_with(1);
    do_step(1'b0, "R2");

    // R10: async reset mid-run
    do_step(1'b1, "R2");
    @(negedge clk); rst_n = 1'b0;
    #1;
    check_out("R10", 16, 0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_out("R10", 16, 0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule